// File: doc/BRIEF.md
# Performance Monitor Global Control Unit

This block is the shared register file of a performance-monitoring unit. It controls a set of general-purpose counter slots and up to three fixed-function event counters. It holds four registers. The first gates all counters at once. The second records overflows. The third clears those records. The fourth carries the per-counter controls of the fixed counters. The counting logic of the general-purpose counters lives elsewhere: that logic reports overflow through one pulse per slot and takes its run enable back from this block. The fixed counters are inside the block. Each one counts its increment events when it is globally enabled and its privilege filter lets the current mode through.

Software reaches every register through a single address/data port. Writes take effect at the clock edge. Reads are combinational. The block's one interrupt output is the OR of every recorded overflow whose interrupt is enabled.

Register map (3-bit address): 0 = fixed-counter control, 1 = global enable, 2 = overflow status (read only), 3 = overflow clear (write only, reads zero), 4+j = value of fixed counter j. Any other address reads zero and ignores writes.

Top module: `pmu_global_ctrl`

## Requirements
- R1: After reset, every register and every fixed counter reads zero, and `irq`, `gp_run` and `fx_run` are low.
- R2: The fixed-counter control register (address 0) holds a 4-bit field for each fixed counter j at bits 4j+3..4j. Inside a field, bit 0 allows counting in kernel mode, bit 1 allows counting in user mode and bit 3 enables the overflow interrupt. Bit 2 of each field, and all bits above field NUM_FX-1, read zero.
- R3: In the global enable register (address 1), bit i drives `gp_run[i]` and bit 32+j drives `fx_run[j]`. Every other bit reads zero and ignores writes.
- R4: A write to the global enable register acts in the cycle of the write. If the written value is zero, `gp_run` and `fx_run` drop in that same cycle, and a fixed counter does not count an increment event that arrives in that cycle.
- R5: A fixed counter adds one at each clock edge where its enable bit is set, `fx_inc[j]` is high and its field allows the current mode. `priv_kernel` high selects field bit 0; `priv_kernel` low selects field bit 1.
- R6: A write to address 4+j loads fixed counter j with all FX_W low bits of the data, with no sign-extension limit. The write takes priority over an increment in the same cycle.
- R7: When fixed counter j steps from all ones to zero, it sets status bit 32+j.
- R8: A pulse on `gp_ovf[i]` sets status bit i at the next clock edge.
- R9: Writing to the overflow-clear register (address 3) clears every status bit written as 1 and leaves every bit written as 0 unchanged. If a set and a clear reach the same bit in one cycle, the set wins. Writes to the status address have no effect.
- R10: Status bit 63 is set when the global enable register is written with a value that differs, after masking, from its current contents. A write of an equal value does not set it.
- R11: A pulse on `buf_ovf_evt` sets status bit 62.
- R12: `irq` is high while any status bit i has `gp_int_en[i]` set, or any status bit 32+j has bit 3 of field j set. It stays high until those status bits are cleared.
- R13: The overflow-clear address, and addresses above the last fixed counter, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (combinational) |
| gp_ovf | input | NUM_GP | Overflow pulses from the general-purpose counters |
| gp_int_en | input | NUM_GP | Interrupt enables of the general-purpose counters |
| fx_inc | input | NUM_FX | Increment events for the fixed counters |
| priv_kernel | input | 1 | High when the current mode is kernel mode |
| buf_ovf_evt | input | 1 | Pulse that sets status bit 62 |
| gp_run | output | NUM_GP | Run enables of the general-purpose counters |
| fx_run | output | NUM_FX | Run enables of the fixed counters |
| irq | output | 1 | Overflow interrupt |

## Verification
Register writes, counter steps and status sets land at the clock edge where the stimulus is present. The bench drives each stimulus at a falling edge and samples one falling edge later, after exactly one rising edge, so it reads the new value. `gp_run`, `fx_run`, `reg_rdata` and `irq` are combinational over the registers and inputs, and the bench samples them 1 ns after it changes an input, before any rising edge. The check that a zero enable write stops counting in the same cycle holds the increment event high across that single edge and then confirms that the count has not moved.

// File: rtl/pmu_gc_pkg.sv
package pmu_gc_pkg;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_FCTL  = 3'd0;
  localparam logic [REG_AW-1:0] A_GEN   = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] A_OCLR  = 3'd3;
  localparam logic [REG_AW-1:0] A_FCNT0 = 3'd4;

  localparam int FX_BASE_BIT = 32;
  localparam int BUF_BIT     = 62;
  localparam int CC_BIT      = 63;
  localparam int FLD_W       = 4;
  localparam logic [FLD_W-1:0] FLD_IMPL = 4'b1011;

  // Implemented bits of the enable and status layout: slots low, fixed from 32.
  function automatic logic [63:0] en_mask(input int ngp, input int nfx);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < ngp) m[i] = 1'b1;
      if (i >= FX_BASE_BIT && i < FX_BASE_BIT + nfx) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [63:0] stat_mask(input int ngp, input int nfx);
    logic [63:0] m;
    m = en_mask(ngp, nfx);
    m[BUF_BIT] = 1'b1;
    m[CC_BIT]  = 1'b1;
    return m;
  endfunction

  // Implemented bits of the shared fixed-counter control register.
  function automatic logic [63:0] fctl_mask(input int nfx);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < FLD_W * nfx) m[i] = FLD_IMPL[2'(i % FLD_W)];
    end
    return m;
  endfunction

  // Privilege filter of one fixed-counter field.
  function automatic logic fx_allowed(input logic [FLD_W-1:0] fld, input logic kernel);
    return kernel ? fld[0] : fld[1];
  endfunction

  // Status update: sets win over clears, unimplemented bits forced low.
  function automatic logic [63:0] stat_next(input logic [63:0] cur, input logic [63:0] set,
                                            input logic [63:0] clr, input logic [63:0] mask);
    return ((cur & ~clr) | set) & mask;
  endfunction

endpackage

// File: rtl/pmu_gc_fixed_ctr.sv
module pmu_gc_fixed_ctr
  import pmu_gc_pkg::*;
#(
  parameter int W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             inc,
  input  logic [FLD_W-1:0] fld,
  input  logic             kernel,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     count,
  output logic             wrap
);

  logic [W-1:0] cnt_q;
  logic         step;

  assign step  = run & inc & fx_allowed(fld, kernel);
  assign wrap  = step & (&cnt_q) & ~wr_en;
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (step)  cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/pmu_gc_status.sv
module pmu_gc_status
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] set_vec,
  input  logic [63:0] clr_vec,
  output logic [63:0] stat_q
);

  localparam logic [63:0] MASK = stat_mask(NUM_GP, NUM_FX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_next(stat_q, set_vec, clr_vec, MASK);
  end

endmodule

// File: rtl/pmu_global_ctrl.sv
module pmu_global_ctrl
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int FX_W   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [NUM_GP-1:0] gp_ovf,
  input  logic [NUM_GP-1:0] gp_int_en,
  input  logic [NUM_FX-1:0] fx_inc,
  input  logic              priv_kernel,
  input  logic              buf_ovf_evt,
  output logic [NUM_GP-1:0] gp_run,
  output logic [NUM_FX-1:0] fx_run,
  output logic              irq
);

  localparam logic [63:0] EN_MASK = en_mask(NUM_GP, NUM_FX);
  localparam logic [63:0] FC_MASK = fctl_mask(NUM_FX);

  // Decoded write strobes
  logic              gen_we, fctl_we, oclr_we;
  logic [NUM_FX-1:0] cnt_we;

  assign gen_we  = reg_we && (reg_addr == A_GEN);
  assign fctl_we = reg_we && (reg_addr == A_FCTL);
  assign oclr_we = reg_we && (reg_addr == A_OCLR);

  // Control registers
  logic [63:0] gen_q, fctl_q, gen_wval, gen_eff;
  logic        gen_change;

  assign gen_wval   = reg_wdata & EN_MASK;
  assign gen_eff    = gen_we ? gen_wval : gen_q;
  assign gen_change = gen_we && (gen_wval != gen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= '0;
      fctl_q <= '0;
    end else begin
      if (gen_we)  gen_q  <= gen_wval;
      if (fctl_we) fctl_q <= reg_wdata & FC_MASK;
    end
  end

  assign gp_run = gen_eff[NUM_GP-1:0];

  // Fixed counters
  logic [FX_W-1:0]        fx_cnt [NUM_FX];
  logic [NUM_FX*FX_W-1:0] fx_cnt_flat;
  logic [NUM_FX-1:0]      fx_wrap;

  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    assign cnt_we[j] = reg_we && (reg_addr == 3'(A_FCNT0 + j));
    assign fx_run[j] = gen_eff[FX_BASE_BIT + j];

    pmu_gc_fixed_ctr #(.W(FX_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (fx_run[j]),
      .inc     (fx_inc[j]),
      .fld     (fctl_q[FLD_W*j +: FLD_W]),
      .kernel  (priv_kernel),
      .wr_en   (cnt_we[j]),
      .wr_data (reg_wdata[FX_W-1:0]),
      .count   (fx_cnt[j]),
      .wrap    (fx_wrap[j])
    );

    assign fx_cnt_flat[FX_W*j +: FX_W] = fx_cnt[j];
  end

  // Overflow status
  logic [63:0] set_vec, clr_vec, stat_q;

  always_comb begin
    set_vec = '0;
    set_vec[NUM_GP-1:0] = gp_ovf;
    for (int j = 0; j < NUM_FX; j++) set_vec[FX_BASE_BIT + j] = fx_wrap[j];
    set_vec[BUF_BIT] = buf_ovf_evt;
    set_vec[CC_BIT]  = gen_change;
  end

  assign clr_vec = oclr_we ? reg_wdata : 64'd0;

  pmu_gc_status #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  // Interrupt
  logic [NUM_GP-1:0] gp_hit;
  logic [NUM_FX-1:0] fx_hit;

  assign gp_hit = stat_q[NUM_GP-1:0] & gp_int_en;
  for (genvar j = 0; j < NUM_FX; j++) begin : g_hit
    assign fx_hit[j] = stat_q[FX_BASE_BIT + j] & fctl_q[FLD_W*j + 3];
  end
  assign irq = (|gp_hit) | (|fx_hit);

  // Read port
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FCTL:  reg_rdata = fctl_q;
      A_GEN:   reg_rdata = gen_q;
      A_STAT:  reg_rdata = stat_q;
      default: begin
        for (int j = 0; j < NUM_FX; j++) begin
          if (reg_addr == 3'(A_FCNT0 + j)) reg_rdata[FX_W-1:0] = fx_cnt[j];
        end
      end
    endcase
  end

endmodule

// File: rtl/pmu_global_ctrl_chk.sv
module pmu_global_ctrl_chk
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int FX_W   = 40
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gen_we,
  input logic [63:0]            reg_wdata,
  input logic [63:0]            gen_q,
  input logic [63:0]            set_vec,
  input logic [63:0]            clr_vec,
  input logic [63:0]            stat_q,
  input logic                   irq,
  input logic [NUM_GP-1:0]      gp_run,
  input logic [NUM_FX-1:0]      fx_run,
  input logic [NUM_FX*FX_W-1:0] fx_cnt_flat
);

  localparam logic [63:0] EMASK = en_mask(NUM_GP, NUM_FX);

  p_stop_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_we && reg_wdata == 64'd0) |-> (gp_run == '0 && fx_run == '0));

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_we && reg_wdata == 64'd0) |=> (fx_cnt_flat == $past(fx_cnt_flat)));

  p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 64'd0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  p_clear_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != 64'd0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == 64'd0));

  p_cond_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_we && ((reg_wdata & EMASK) != gen_q)) |=> stat_q[CC_BIT]);

  p_quiet_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 64'd0) |-> !irq);

endmodule

bind pmu_global_ctrl pmu_global_ctrl_chk #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .FX_W(FX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_we      (gen_we),
  .reg_wdata   (reg_wdata),
  .gen_q       (gen_q),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .stat_q      (stat_q),
  .irq         (irq),
  .gp_run      (gp_run),
  .fx_run      (fx_run),
  .fx_cnt_flat (fx_cnt_flat)
);

// File: tb/pmu_global_ctrl_test.sv
module pmu_global_ctrl_test;

  localparam int NGP = 4;
  localparam int NFX = 3;
  localparam logic [2:0] FCTL = 3'd0, GEN = 3'd1, STAT = 3'd2, OCLR = 3'd3;
  localparam logic [2:0] FX0 = 3'd4, FX1 = 3'd5, FX2 = 3'd6, NONE = 3'd7;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [63:0]     reg_wdata = '0;
  logic [63:0]     reg_rdata;
  logic [NGP-1:0]  gp_ovf = '0;
  logic [NGP-1:0]  gp_int_en = '0;
  logic [NFX-1:0]  fx_inc = '0;
  logic            priv_kernel = 1'b0;
  logic            buf_ovf_evt = 1'b0;
  logic [NGP-1:0]  gp_run;
  logic [NFX-1:0]  fx_run;
  logic            irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pmu_global_ctrl #(.NUM_GP(NGP), .NUM_FX(NFX), .FX_W(40)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gp_ovf(gp_ovf),
    .gp_int_en(gp_int_en), .fx_inc(fx_inc), .priv_kernel(priv_kernel),
    .buf_ovf_evt(buf_ovf_evt), .gp_run(gp_run), .fx_run(fx_run), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  wa;
    logic [63:0] wd;
    logic [2:0]  ra;
    logic [63:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{FCTL, ONES, FCTL, 64'h0000_0000_0000_0BBB, 8'd2},                    // R2 bit 2 and high bits read 0
    '{FCTL, 64'h321, FCTL, 64'h0000_0000_0000_0321, 8'd2},                  // R2
    '{GEN, ONES, GEN, 64'h0000_0007_0000_000F, 8'd3},                       // R3
    '{OCLR, 64'd0, STAT, 64'h8000_0000_0000_0000, 8'd10},                   // R10 changed value; R9 zeros
    '{OCLR, 64'h8000_0000_0000_0000, STAT, 64'd0, 8'd9},                    // R9
    '{GEN, 64'h0000_0007_0000_000F, STAT, 64'd0, 8'd10},                    // R10 equal value
    '{STAT, ONES, STAT, 64'd0, 8'd9},                                       // R9 status write ignored
    '{OCLR, ONES, OCLR, 64'd0, 8'd13},                                      // R13
    '{NONE, 64'h1234, NONE, 64'd0, 8'd13},                                  // R13
    '{GEN, 64'd0, GEN, 64'd0, 8'd3},                                        // R3
    '{FX0, 64'h1234_5678_9ABC_DEF0, FX0, 64'h0000_0078_9ABC_DEF0, 8'd6},    // R6
    '{FX2, 64'h0000_00FF_FFFF_FFFF, FX2, 64'h0000_00FF_FFFF_FFFF, 8'd6}     // R6
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(FCTL, v); check("R1 fctl", v, 0);
    rd(GEN, v);  check("R1 gen", v, 0);
    rd(STAT, v); check("R1 stat", v, 0);
    rd(FX1, v);  check("R1 fx1", v, 0);
    check("R1 irq/run", {irq, gp_run, fx_run}, 0);

    for (int k = 0; k < NV; k++) begin
      wr(VECS[k].wa, VECS[k].wd);
      rd(VECS[k].ra, v);
      if (v !== VECS[k].ex) begin
        n_run++; n_fail++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[k].req, k, v, VECS[k].ex);
      end else n_run++;
    end

    // R5 privilege filter
    wr(OCLR, ONES);
    wr(FCTL, 64'h21);
    wr(FX0, 0); wr(FX1, 0);
    wr(GEN, 64'h0000_0003_0000_0000);
    @(negedge clk); priv_kernel = 1'b1; fx_inc = 3'b011;
    repeat (3) @(negedge clk);
    fx_inc = 0;
    rd(FX0, v); check("R5 kernel fx0", v, 3);
    rd(FX1, v); check("R5 kernel fx1", v, 0);
    priv_kernel = 1'b0; fx_inc = 3'b011;
    repeat (2) @(negedge clk);
    fx_inc = 0;
    rd(FX0, v); check("R5 user fx0", v, 3);
    rd(FX1, v); check("R5 user fx1", v, 2);

    // R3 / R4 immediate stop
    wr(GEN, 64'h0000_0003_0000_000F);
    #1; check("R3 gp_run", 64'(gp_run), 64'hF);
    @(negedge clk);
    priv_kernel = 1'b1; fx_inc = 3'b001;
    reg_addr = GEN; reg_wdata = 0; reg_we = 1'b1;
    #1; check("R4 run same cycle", 64'({gp_run, fx_run}), 0);
    @(negedge clk);
    reg_we = 1'b0; fx_inc = 0;
    rd(FX0, v); check("R4 no count", v, 3);

    // R6 write beats increment
    wr(GEN, 64'h0000_0001_0000_0000);
    @(negedge clk);
    fx_inc = 3'b001; reg_addr = FX0; reg_wdata = 64'd100; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; fx_inc = 0;
    rd(FX0, v); check("R6 write wins", v, 100);

    // R7 / R12 wrap with interrupt enabled
    wr(FCTL, 64'h9);
    wr(FX0, 64'h0000_00FF_FFFF_FFFF);
    wr(OCLR, ONES);
    #1; check("R12 irq idle", 64'(irq), 0);
    @(negedge clk); fx_inc = 3'b001;
    @(negedge clk); fx_inc = 0;
    rd(STAT, v); check("R7 wrap status", v, 64'h0000_0001_0000_0000);
    rd(FX0, v);  check("R7 wrapped to 0", v, 0);
    check("R12 irq set", 64'(irq), 1);
    repeat (4) @(negedge clk);
    #1; check("R12 irq held", 64'(irq), 1);
    wr(OCLR, 64'h0000_0001_0000_0000);
    #1; check("R12 irq cleared", 64'(irq), 0);

    // R12 wrap without interrupt enable
    wr(FCTL, 64'h1);
    wr(FX0, 64'h0000_00FF_FFFF_FFFF);
    @(negedge clk); fx_inc = 3'b001;
    @(negedge clk); fx_inc = 0;
    rd(STAT, v); check("R7 wrap no pmi", v, 64'h0000_0001_0000_0000);
    check("R12 no pmi irq", 64'(irq), 0);

    // R8 general-purpose overflow
    wr(GEN, 0);
    wr(OCLR, ONES);
    @(negedge clk); gp_ovf = 4'b0100;
    @(negedge clk); gp_ovf = 0;
    rd(STAT, v); check("R8 gp status", v, 64'h4);
    check("R12 gp masked", 64'(irq), 0);
    gp_int_en = 4'b0100;
    #1; check("R12 gp enabled", 64'(irq), 1);
    gp_int_en = 0;

    // R9 set wins over clear
    @(negedge clk);
    gp_ovf = 4'b0010; reg_addr = OCLR; reg_wdata = 64'h6; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; gp_ovf = 0;
    rd(STAT, v); check("R9 set wins", v, 64'h2);

    // R11 buffer-overflow flag
    wr(OCLR, ONES);
    @(negedge clk); buf_ovf_evt = 1'b1;
    @(negedge clk); buf_ovf_evt = 1'b0;
    rd(STAT, v); check("R11 buf flag", v, 64'h4000_0000_0000_0000);

    // R1 reset again
    wr(FCTL, 64'h9); wr(GEN, 64'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(GEN, v);  check("R1 gen after reset", v, 0);
    rd(FCTL, v); check("R1 fctl after reset", v, 0);
    rd(STAT, v); check("R1 stat after reset", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule